// File: doc/BRIEF.md
# Link Rate and Lane Selector

This block picks the serial link configuration for a requested video mode. It takes the sink's advertised maximum rate code, its lane-count capability byte and the mode's pixel clock in kHz, and searches a fixed bandwidth table for the cheapest configuration that carries the mode. The result is a lane count (1, 2 or 4), a link rate in kHz (162000 or 270000) and a flag that says whether the mode fits the link at all.

The table holds six bandwidth products, in kHz. Indices 0 and 1 are one lane at the low and high rate (54000, 90000). Indices 2 and 3 are two lanes (108000, 180000). Indices 4 and 5 are four lanes (216000, 360000). Each query starts with a one-cycle `start` pulse. The capability inputs are captured at that point. The block then steps through the table at one index per clock and raises `done` with the result. The capability bytes reach the block as plain input values, already read from the sink.

Top module: `linkcfg_select`

## Requirements
- R1: After reset, `busy`, `done`, `mode_ok`, `lane_cnt` and `link_rate` are all 0.
- R2: The search selects the first usable table index whose value is strictly greater than the mode clock. An equal value does not qualify. Indices 0–1 give `lane_cnt`=1, indices 2–3 give 2 and indices 4–5 give 4.
- R3: Only the rate code 8'h0A allows the odd (high-rate) table indices. Any other code, including 8'h06, makes every odd index unusable, so the result rate is then always 162000.
- R4: Only bits [4:0] of the lane capability byte are used. A masked value of 1 limits the search to indices 0–1. A masked value of 2 limits it to indices 0–3. Any other masked value allows indices 0–5.
- R5: A selected odd index gives `link_rate`=270000 and a selected even index gives 162000.
- R6: If no usable index within the lane limit qualifies, `lane_cnt`=0, `link_rate`=0 and `mode_ok`=0. Otherwise `mode_ok`=1.
- R7: An accepted start raises `busy` at that edge. The block examines one table index per clock, odd indices under a low-rate cap included. `done` rises (n+1) clocks after the accepting edge, where n is the selected index, or on failure the last index the lane limit allows (1, 3 or 5). `busy` and `done` are never high together.
- R8: While `done` is high and no start arrives, the outputs hold their values. A start accepted in that state clears `done` and begins a new query.
- R9: A start that arrives while `busy` is high is ignored. The running query finishes with its original inputs and its original timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Query request pulse, taken only when not busy |
| max_rate_code | input | 8 | Sink maximum rate code (8'h0A = high rate) |
| lane_cap_byte | input | 8 | Sink lane capability byte, low 5 bits used |
| mode_clk_khz | input | 32 | Pixel clock of the requested mode, kHz |
| busy | output | 1 | Query in progress |
| done | output | 1 | Result valid, held until next accepted start |
| lane_cnt | output | 3 | Selected lane count (0, 1, 2 or 4) |
| link_rate | output | 19 | Selected link rate in kHz (0, 162000, 270000) |
| mode_ok | output | 1 | Mode fits the link |

## Verification
The bench targets mode clocks that equal a table entry exactly. A design that compared with greater-or-equal would pick that entry instead of the next one. Under a low-rate code, it uses clocks that only an odd entry could carry. A design that did not skip odd entries would report 270000 or a smaller lane count where the query should fail or move to a wider even entry. Lane capability bytes with high bits set, and masked values outside {1,2}, expose a design that skips the mask or the default case. The bench also counts the clocks to `done` for every query and issues starts while a query is busy. A design that skipped entries, stopped late, or restarted on a mid-query start would show a wrong latency or a result computed from the intruding inputs.

// File: rtl/linkcfg_pkg.sv
// Shared constants and table helpers for the link configuration selector.
// Assumes a table of three lane widths (1, 2, 4), each at a low and a high rate.
package linkcfg_pkg;
    localparam int NUM_WIDTHS  = 3;
    localparam int NUM_ENTRIES = 2 * NUM_WIDTHS;
    localparam int IDX_W       = $clog2(NUM_ENTRIES);
    localparam int RATE_LO     = 162000;
    localparam int RATE_HI     = 270000;
    localparam int SYM_DIV     = 3;
    localparam logic [7:0] CODE_HI   = 8'h0A;
    localparam logic [7:0] LANE_MASK = 8'h1F;

    // Bandwidth product of a table index in kHz.
    function automatic logic [31:0] entry_kbps(int i);
        int r;
        r = (i % 2 != 0) ? RATE_HI : RATE_LO;
        return 32'((r * (1 << (i / 2))) / SYM_DIV);
    endfunction

    // Lane count of a table index.
    function automatic logic [2:0] entry_lanes(int i);
        return 3'(1 << (i / 2));
    endfunction
endpackage

// File: rtl/linkcfg_cap_decode.sv
// Decodes the sink capability bytes into a high-rate enable and the last
// table index the lane limit allows. Purely combinational.
module linkcfg_cap_decode
    import linkcfg_pkg::*;
(
    input  logic [7:0]       rate_code,
    input  logic [7:0]       lane_byte,
    output logic             hi_rate_en,
    output logic [IDX_W-1:0] last_idx
);
    logic [7:0] lane_cap;

    // Mask the lane byte and map the limit to a final index.
    always_comb begin
        lane_cap   = lane_byte & LANE_MASK;
        hi_rate_en = (rate_code == CODE_HI);
        case (lane_cap)
            8'd1:    last_idx = IDX_W'(1);
            8'd2:    last_idx = IDX_W'(3);
            default: last_idx = IDX_W'(NUM_ENTRIES - 1);
        endcase
    end
endmodule

// File: rtl/linkcfg_table.sv
// Fixed bandwidth table, built by generate from the package helpers.
// Assumes idx may exceed the table; out-of-range reads return zeros.
module linkcfg_table
    import linkcfg_pkg::*;
(
    input  logic [IDX_W-1:0] idx,
    output logic [31:0]      kbps,
    output logic [2:0]       lanes
);
    logic [31:0] kbps_arr  [NUM_ENTRIES];
    logic [2:0]  lanes_arr [NUM_ENTRIES];

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_entry
        assign kbps_arr[g]  = entry_kbps(g);
        assign lanes_arr[g] = entry_lanes(g);
    end

    // Select the addressed entry.
    always_comb begin
        kbps  = '0;
        lanes = '0;
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            if (idx == IDX_W'(i)) begin
                kbps  = kbps_arr[i];
                lanes = lanes_arr[i];
            end
        end
    end
endmodule

// File: rtl/linkcfg_scan.sv
// Sequential search: captures a query on start, visits one table index per
// clock and registers the result. Assumes synchronous active-low reset.
module linkcfg_scan
    import linkcfg_pkg::*;
#(
    parameter int CLK_W  = 32,
    parameter int RATE_W = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CLK_W-1:0]  mode_clk,
    input  logic              hi_rate_en,
    input  logic [IDX_W-1:0]  last_idx,
    input  logic [31:0]       ent_kbps,
    input  logic [2:0]        ent_lanes,
    output logic [IDX_W-1:0]  idx,
    output logic              busy,
    output logic              done,
    output logic [2:0]        lane_cnt,
    output logic [RATE_W-1:0] link_rate,
    output logic              mode_ok
);
    logic [CLK_W-1:0] clk_q;
    logic             hi_q;
    logic [IDX_W-1:0] last_q;
    logic             usable;
    logic             hit;

    // Entry qualifies when usable under the rate cap and strictly above the mode clock.
    always_comb begin
        usable = hi_q || !idx[0];
        hit    = usable && (ent_kbps > 32'(clk_q));
    end

    // Query capture, index stepping and result registration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            done      <= 1'b0;
            idx       <= '0;
            clk_q     <= '0;
            hi_q      <= 1'b0;
            last_q    <= '0;
            lane_cnt  <= '0;
            link_rate <= '0;
            mode_ok   <= 1'b0;
        end else if (start && !busy) begin
            busy   <= 1'b1;
            done   <= 1'b0;
            idx    <= '0;
            clk_q  <= mode_clk;
            hi_q   <= hi_rate_en;
            last_q <= last_idx;
        end else if (busy) begin
            if (hit) begin
                busy      <= 1'b0;
                done      <= 1'b1;
                lane_cnt  <= ent_lanes;
                link_rate <= idx[0] ? RATE_W'(RATE_HI) : RATE_W'(RATE_LO);
                mode_ok   <= 1'b1;
            end else if (idx == last_q) begin
                busy      <= 1'b0;
                done      <= 1'b1;
                lane_cnt  <= '0;
                link_rate <= '0;
                mode_ok   <= 1'b0;
            end else begin
                idx <= idx + 1'b1;
            end
        end
    end

    assert_busy_done_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));
    assert_idx_within_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (idx <= last_q));
    assert_query_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(clk_q) && $stable(hi_q) && $stable(last_q)));
    assert_result_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(lane_cnt) && $stable(link_rate) && $stable(mode_ok)));
    assert_lanes_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lane_cnt));
    assert_fail_zeroes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((mode_ok == (lane_cnt != 3'd0)) && (mode_ok == (link_rate != '0))));
    assert_rate_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && mode_ok) |-> ((link_rate == RATE_W'(RATE_LO)) || (link_rate == RATE_W'(RATE_HI))));
    assert_low_cap_rate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !hi_q) |-> (link_rate != RATE_W'(RATE_HI)));
endmodule

// File: rtl/linkcfg_select.sv
// Top of the link configuration selector: decodes the capability bytes and
// runs the table search. Assumes inputs are synchronous to clk.
module linkcfg_select
    import linkcfg_pkg::*;
#(
    parameter int CLK_W  = 32,
    parameter int RATE_W = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [7:0]        max_rate_code,
    input  logic [7:0]        lane_cap_byte,
    input  logic [CLK_W-1:0]  mode_clk_khz,
    output logic              busy,
    output logic              done,
    output logic [2:0]        lane_cnt,
    output logic [RATE_W-1:0] link_rate,
    output logic              mode_ok
);
    logic             hi_rate_en;
    logic [IDX_W-1:0] last_idx;
    logic [IDX_W-1:0] scan_idx;
    logic [31:0]      ent_kbps;
    logic [2:0]       ent_lanes;

    linkcfg_cap_decode u_cap (
        .rate_code  (max_rate_code),
        .lane_byte  (lane_cap_byte),
        .hi_rate_en (hi_rate_en),
        .last_idx   (last_idx)
    );

    linkcfg_table u_tbl (
        .idx   (scan_idx),
        .kbps  (ent_kbps),
        .lanes (ent_lanes)
    );

    linkcfg_scan #(.CLK_W(CLK_W), .RATE_W(RATE_W)) u_scan (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .mode_clk   (mode_clk_khz),
        .hi_rate_en (hi_rate_en),
        .last_idx   (last_idx),
        .ent_kbps   (ent_kbps),
        .ent_lanes  (ent_lanes),
        .idx        (scan_idx),
        .busy       (busy),
        .done       (done),
        .lane_cnt   (lane_cnt),
        .link_rate  (link_rate),
        .mode_ok    (mode_ok)
    );
endmodule

// File: tb/linkcfg_select_bench.sv
`timescale 1ns/1ps
module linkcfg_select_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  max_rate_code = 8'h0;
    logic [7:0]  lane_cap_byte = 8'h0;
    logic [31:0] mode_clk_khz = '0;
    logic        busy, done, mode_ok;
    logic [2:0]  lane_cnt;
    logic [18:0] link_rate;
    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    linkcfg_select u_linkcfg_select (
        .clk(clk), .rst_n(rst_n), .start(start),
        .max_rate_code(max_rate_code), .lane_cap_byte(lane_cap_byte),
        .mode_clk_khz(mode_clk_khz), .busy(busy), .done(done),
        .lane_cnt(lane_cnt), .link_rate(link_rate), .mode_ok(mode_ok)
    );

    task automatic chk(input bit good, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!good) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Reference model written from R2..R6: returns index or -1, and stop index.
    task automatic ref_model(input logic [7:0] code, input logic [7:0] cap,
                             input int mclk, output int sel, output int stop_at);
        int tbl[6] = '{54000, 90000, 108000, 180000, 216000, 360000};
        int lim;
        int m = cap & 8'h1F;
        lim = (m == 1) ? 1 : (m == 2) ? 3 : 5;
        sel = -1;
        stop_at = lim;
        for (int i = 0; i <= lim; i++) begin
            if ((code == 8'h0A || i % 2 == 0) && tbl[i] > mclk) begin
                sel = i;
                stop_at = i;
                break;
            end
        end
    endtask

    // Issue one query; optional intruding start during busy (R9).
    task automatic run_query(input string name, input logic [7:0] code,
                             input logic [7:0] cap, input int mclk,
                             input bit intrude);
        int sel, stop_at, cyc, exp_lanes, exp_rate;
        ref_model(code, cap, mclk, sel, stop_at);
        @(negedge clk);
        max_rate_code = code; lane_cap_byte = cap; mode_clk_khz = 32'(mclk);
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        chk(busy === 1'b1 && done === 1'b0, "R7", {name, " busy after start"}, busy, 1);
        cyc = 0;
        if (intrude && !done) begin
            max_rate_code = 8'h0A; lane_cap_byte = 8'h04; mode_clk_khz = 32'd1;
            start = 1'b1;
        end
        while (!done && cyc < 40) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
            start = 1'b0;
            if (!done) chk(busy === 1'b1, "R7", {name, " busy while scanning"}, busy, 1);
        end
        exp_lanes = (sel < 0) ? 0 : (1 << (sel / 2));
        exp_rate  = (sel < 0) ? 0 : ((sel % 2) ? 270000 : 162000);
        chk(cyc == stop_at + 1, intrude ? "R9" : "R7", {name, " cycles to done"}, cyc, stop_at + 1);
        chk(busy === 1'b0, "R7", {name, " busy low at done"}, busy, 0);
        chk(lane_cnt == 3'(exp_lanes), (sel < 0) ? "R6" : "R2", {name, " lanes"}, lane_cnt, exp_lanes);
        chk(link_rate == 19'(exp_rate), (sel < 0) ? "R6" : "R5", {name, " rate"}, link_rate, exp_rate);
        chk(mode_ok == (sel >= 0), "R6", {name, " mode_ok"}, mode_ok, (sel >= 0));
    endtask

    task automatic t_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!busy && !done && !mode_ok && lane_cnt == 0 && link_rate == 0,
            "R1", "reset outputs", {busy, done, mode_ok}, 0);
        rst_n = 1'b1;
    endtask

    task automatic t_high_rate_scan();
        run_query("hi clk50000",  8'h0A, 8'h04, 50000,  0); // R2 index 0
        run_query("hi eq54000",   8'h0A, 8'h04, 54000,  0); // R2 strict: index 1
        run_query("hi clk100000", 8'h0A, 8'h04, 100000, 0); // R2 index 2
        run_query("hi eq216000",  8'h0A, 8'h04, 216000, 0); // R5 index 5
        run_query("hi clk200000", 8'h0A, 8'h04, 200000, 0); // index 4
        run_query("hi eq360000",  8'h0A, 8'h04, 360000, 0); // R6 fail
    endtask

    task automatic t_low_rate_scan();
        run_query("lo clk60000",  8'h06, 8'h04, 60000,  0); // R3 skips 90000
        run_query("lo code55",    8'h55, 8'h04, 200000, 0); // R3 unknown code
        run_query("lo clk250000", 8'h06, 8'h04, 250000, 0); // R3 fail
        run_query("lo cap1",      8'h06, 8'h01, 60000,  0); // R3+R4 fail at 1
    endtask

    task automatic t_lane_caps();
        run_query("cap1 60000",   8'h0A, 8'h01, 60000,  0); // R4
        run_query("cap1 95000",   8'h0A, 8'h01, 95000,  0); // R4 fail
        run_query("cap82 150000", 8'h0A, 8'h82, 150000, 0); // R4 masked to 2
        run_query("cap82 190000", 8'h0A, 8'h82, 190000, 0); // R4 fail at 3
        run_query("cap03 200000", 8'h0A, 8'h03, 200000, 0); // R4 default
        run_query("cap21 95000",  8'h0A, 8'h21, 95000,  0); // R4 masked to 1
    endtask

    task automatic t_hold();
        logic [2:0]  l0;
        logic [18:0] r0;
        run_query("hold base", 8'h0A, 8'h04, 150000, 0);
        l0 = lane_cnt; r0 = link_rate;
        max_rate_code = 8'h00; lane_cap_byte = 8'h01; mode_clk_khz = 32'd999999;
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk(done && lane_cnt == l0 && link_rate == r0, "R8", "held result", link_rate, r0);
        run_query("hold restart", 8'h0A, 8'h04, 10, 0); // R8 new start accepted
    endtask

    task automatic t_busy_start();
        run_query("intrude", 8'h0A, 8'h04, 300000, 1); // R9
        run_query("intrude fail", 8'h06, 8'h02, 150000, 1); // R9
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_high_rate_scan();
        t_low_rate_scan();
        t_lane_caps();
        t_hold();
        t_busy_start();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule